// File: doc/BRIEF.md
# Time-Sliced Execution Lease Controller

This block is a small synchronous state machine that grants a bounded slice of time to one of two execution domains and always takes control back when that slice is used up. A supervisor (hub) state loads a countdown, picks a domain and hands control to the first state of that domain's pair of worker states. The two domains take turns: the first grant after reset goes to the untrusted pair, the next to the trusted pair, and so on.

While a lease is running, one shared piece of group logic does the same work in every worker cycle, whichever domain holds the lease. It counts the lease down and forces the return to the hub when the count reaches zero. The same logic reads one selector register to decide whether the worker stays in its state or hops to its sibling. Which of the two selector registers it reads is fixed when the hub dispatches. Each selector register can be written from outside. The outputs show the current state, the domain now executing and the live countdown value.

Top module: `lease_ctrl`

## Requirements
- R1: After a synchronous active-low reset, state_o is 0 (hub), timer_o is 0 and domain_o is 0. The first dispatch after reset goes to the untrusted pair.
- R2: State codes on state_o are: 0 hub, 1 untrusted first, 2 untrusted second, 3 trusted first, 4 trusted second. The hub lasts exactly one cycle, and it always enters the first state of the chosen pair (1 or 3).
- R3: Dispatches from the hub alternate between the untrusted pair and the trusted pair.
- R4: On dispatch, the timer is loaded with lease_len minus one. A lease_len of 0 is treated as 1.
- R5: In each worker cycle with a nonzero timer, the timer decrements by one. A worker cycle with timer 0 returns to the hub, and the timer stays at 0. A lease therefore spans max(lease_len,1) worker cycles.
- R6: When the timer has not expired, bit 0 of the bound selector decides the move: 1 hops to the sibling state (1↔2, 3↔4) and 0 stays. The untrusted pair reads selector register U and the trusted pair reads register T.
- R7: Writes to the selector register of the domain that does not hold the lease have no effect on that lease's state sequence.
- R8: domain_o is 1 exactly in states 1 and 2, and 0 in the hub and the trusted states.
- R9: A selector write stores its data at the clock edge, and the new value steers moves from the next cycle. Reset clears both selector registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lease_len | input | TW | Lease length in worker cycles, sampled in the hub state |
| sel_u_we | input | 1 | Write enable for selector register U (untrusted) |
| sel_u_wdata | input | DW | Write data for selector register U |
| sel_t_we | input | 1 | Write enable for selector register T (trusted) |
| sel_t_wdata | input | DW | Write data for selector register T |
| state_o | output | 3 | Current state code |
| domain_o | output | 1 | 1 while the untrusted pair executes |
| timer_o | output | TW | Remaining lease count |

## Verification
The bench goes after the boundary lengths. A lease_len of 0 must give a one-cycle lease; a design that loads 0 minus 1 would wrap to a huge lease. A lease_len of 1 must expire on its first worker cycle. An off-by-one load would stretch or shorten every lease by a cycle. The bench also writes the idle domain's selector throughout a lease. A design that binds the wrong register, or muxes it late, would hop when it should stay. Finally it checks that domains strictly alternate and that a hub dispatch never lands on a second-listed state.

// File: rtl/lease_pkg.sv
// Shared types for the lease controller.
// Assumes: state codes are observed at the top port and must not change.
package lease_pkg;
    typedef enum logic [2:0] {
        LS_HUB = 3'd0,
        LS_U_A = 3'd1,
        LS_U_B = 3'd2,
        LS_T_A = 3'd3,
        LS_T_B = 3'd4
    } lease_state_e;
endpackage

// File: rtl/lease_sel_regs.sv
// Two externally writable selector registers, index 0 = untrusted (U), 1 = trusted (T).
// Assumes: synchronous active-low reset clears both.
module lease_sel_regs #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    we,
    input  logic [DW-1:0] wdata [2],
    output logic [DW-1:0] q     [2]
);
    for (genvar g = 0; g < 2; g++) begin : g_reg
        // Capture write data on enable; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)        q[g] <= '0;
            else if (we[g])    q[g] <= wdata[g];
        end
    end
endmodule

// File: rtl/lease_group.sv
// Shared countdown-and-return logic used by every worker state of both domains.
// Assumes: bind_untr was fixed at dispatch and selects which selector bit steers.
module lease_group #(
    parameter int TW = 8
) (
    input  logic [TW-1:0] timer_q,
    input  logic          bind_untr,
    input  logic          sel_u_bit,
    input  logic          sel_t_bit,
    output logic          expired,
    output logic [TW-1:0] timer_nxt,
    output logic          hop
);
    // Decrement, detect expiry and mux the bound selector bit.
    always_comb begin
        expired   = (timer_q == '0);
        timer_nxt = expired ? '0 : timer_q - 1'b1;
        hop       = bind_untr ? sel_u_bit : sel_t_bit;
    end
endmodule

// File: rtl/lease_ctrl.sv
// Execution lease controller: the hub loads a countdown and alternately dispatches
// to an untrusted or trusted pair of worker states; shared group logic counts down,
// steers hops from the bound selector and forces return to the hub at expiry.
// Assumes: lease_len is sampled only in the hub state; 0 is treated as 1.
module lease_ctrl #(
    parameter int TW = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] lease_len,
    input  logic          sel_u_we,
    input  logic [DW-1:0] sel_u_wdata,
    input  logic          sel_t_we,
    input  logic [DW-1:0] sel_t_wdata,
    output logic [2:0]    state_o,
    output logic          domain_o,
    output logic [TW-1:0] timer_o
);
    import lease_pkg::*;

    lease_state_e  state_q, state_d;
    logic [TW-1:0] timer_q, timer_d;
    logic          mode_q, mode_d;
    logic          bind_q, bind_d;
    logic [TW-1:0] load_val;
    logic          expired, hop;
    logic [TW-1:0] timer_dec;
    logic [DW-1:0] sel_wd [2];
    logic [DW-1:0] sel_q  [2];

    assign sel_wd[0] = sel_u_wdata;
    assign sel_wd[1] = sel_t_wdata;

    lease_sel_regs #(.DW(DW)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .we({sel_t_we, sel_u_we}),
        .wdata(sel_wd),
        .q(sel_q)
    );

    lease_group #(.TW(TW)) u_grp (
        .timer_q(timer_q), .bind_untr(bind_q),
        .sel_u_bit(sel_q[0][0]), .sel_t_bit(sel_q[1][0]),
        .expired(expired), .timer_nxt(timer_dec), .hop(hop)
    );

    // Lease length to load, with zero clamped to a single cycle.
    assign load_val = (lease_len == '0) ? '0 : lease_len - 1'b1;

    // Next-state, countdown and domain binding.
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        mode_d  = mode_q;
        bind_d  = bind_q;
        if (state_q == LS_HUB) begin
            timer_d = load_val;
            mode_d  = ~mode_q;
            bind_d  = ~mode_q;
            state_d = mode_q ? LS_T_A : LS_U_A;
        end else begin
            timer_d = timer_dec;
            if (expired) state_d = LS_HUB;
            else if (hop) begin
                case (state_q)
                    LS_U_A:  state_d = LS_U_B;
                    LS_U_B:  state_d = LS_U_A;
                    LS_T_A:  state_d = LS_T_B;
                    default: state_d = LS_T_A;
                endcase
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_HUB;
            timer_q <= '0;
            mode_q  <= 1'b0;
            bind_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
            mode_q  <= mode_d;
            bind_q  <= bind_d;
        end
    end

    assign state_o  = state_q;
    assign timer_o  = timer_q;
    assign domain_o = (state_q == LS_U_A) || (state_q == LS_U_B);

    // Hub always lands on the first state of the pair chosen by mode.
    assert_hub_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_HUB) |=> (state_q == ($past(mode_q) ? LS_T_A : LS_U_A)));

    // Expiry in any worker state returns to the hub.
    assert_expiry_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LS_HUB && timer_q == '0) |=> (state_q == LS_HUB && timer_q == '0));

    // Live lease decrements by one.
    assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LS_HUB && timer_q != '0) |=> (timer_q == $past(timer_q) - 1'b1));

    // Untrusted domain only starts from a hub dispatch.
    assert_domain_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(domain_o) |-> ($past(state_q) == LS_HUB));

    // Worker states never cross into the other pair.
    assert_pair_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_U_A || state_q == LS_U_B) |=>
        (state_q == LS_HUB || state_q == LS_U_A || state_q == LS_U_B));
endmodule

// File: tb/lease_ctrl_test.sv
// Self-checking bench: sweeps lease lengths and selector write patterns against
// an arithmetic model built from the requirements.
module lease_ctrl_test;
    localparam int TW = 8;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [TW-1:0] lease_len;
    logic          sel_u_we, sel_t_we;
    logic [DW-1:0] sel_u_wdata, sel_t_wdata;
    logic [2:0]    state_o;
    logic          domain_o;
    logic [TW-1:0] timer_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int m_state, m_timer, m_mode, m_u, m_t;
    logic [7:0] lf = 8'h5A;

    lease_ctrl #(.TW(TW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .lease_len(lease_len),
        .sel_u_we(sel_u_we), .sel_u_wdata(sel_u_wdata),
        .sel_t_we(sel_t_we), .sel_t_wdata(sel_t_wdata),
        .state_o(state_o), .domain_o(domain_o), .timer_o(timer_o)
    );

    always #4 clk = ~clk;

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive inputs, advance the model, then compare after the edge.
    task automatic cycle(input int len, input bit uwe, input int ud,
                         input bit twe, input int td, input string ovr);
        int pst, ptm, sel, clamp;
        string stag, ttag;
        lease_len = len[TW-1:0]; sel_u_we = uwe; sel_u_wdata = ud[DW-1:0];
        sel_t_we = twe; sel_t_wdata = td[DW-1:0];
        pst = m_state; ptm = m_timer;
        if (m_state == 0) begin
            clamp   = (len == 0) ? 1 : len;
            m_timer = clamp - 1;
            m_state = (m_mode == 1) ? 3 : 1;
            m_mode  = 1 - m_mode;
        end else if (m_timer == 0) begin
            m_state = 0;
        end else begin
            m_timer = m_timer - 1;
            sel = (m_state <= 2) ? (m_u & 1) : (m_t & 1);
            if (sel == 1) m_state = (m_state == 1) ? 2 : (m_state == 2) ? 1 :
                                    (m_state == 3) ? 4 : 3;
        end
        if (uwe) m_u = ud % (1 << DW);
        if (twe) m_t = td % (1 << DW);
        stag = (ovr != "") ? ovr : (pst == 0) ? "R3" : (ptm == 0) ? "R5" : "R6";
        ttag = (pst == 0) ? "R4" : "R5";
        @(posedge clk); @(negedge clk);
        chk(stag, int'(state_o), m_state);
        chk(ttag, int'(timer_o), m_timer);
        chk("R8", int'(domain_o), (m_state == 1 || m_state == 2) ? 1 : 0);
        if (pst == 0) chk("R2", (state_o == 3'd1 || state_o == 3'd3) ? 1 : 0, 1);
    endtask

    initial begin
        rst_n = 1'b0; lease_len = '0;
        sel_u_we = 0; sel_t_we = 0; sel_u_wdata = '0; sel_t_wdata = '0;
        repeat (3) @(negedge clk);
        // Reset state (R1)
        chk("R1", int'(state_o), 0);
        chk("R1", int'(timer_o), 0);
        chk("R1", int'(domain_o), 0);
        rst_n = 1'b1;
        m_state = 0; m_timer = 0; m_mode = 0; m_u = 0; m_t = 0;

        // Cleared selectors keep the first untrusted lease in state 1 (R9, R1)
        for (int i = 0; i < 5; i++) cycle(3, 0, 0, 0, 0, "R9");

        // Write U=1 then expect hops on the following trusted/untrusted leases (R9)
        cycle(4, 1, 1, 1, 1, "R9");
        for (int i = 0; i < 12; i++) cycle(4, 0, 0, 0, 0, "R9");

        // Sweep lease lengths and write patterns
        for (int L = 0; L <= 6; L++) begin
            for (int p = 0; p < 4; p++) begin
                for (int n = 0; n < 2 * (L + 2) + 2; n++) begin
                    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                    cycle(L, p[0] & lf[1], int'(lf[3:0]), p[1] & lf[2], int'(lf[7:4]), "");
                end
            end
        end

        // Idle-domain writes during an untrusted lease (R7)
        while (!(m_state == 0 && m_mode == 0)) cycle(2, 0, 0, 0, 0, "");
        cycle(6, 1, 0, 1, 1, "R7");
        for (int i = 0; i < 7; i++) cycle(6, 0, 0, 1, (i % 2) + 1, "R7");
        // Idle-domain writes during a trusted lease: T=0, hammer U
        cycle(6, 1, 1, 1, 0, "R7");
        for (int i = 0; i < 7; i++) cycle(6, 1, 1, 0, 0, "R7");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule